// File: doc/BRIEF.md
# Four-Requester Bus Arbiter

This block decides which of four requesters owns a shared bus. Requester 0 is the CPU's internal request line; requesters 1 to 3 are external bus masters, each with its own request and grant wire. A two-bit mode input selects the policy used to pick a winner: fixed priority, full rotation, a hybrid scheme in which the CPU always wins and the external masters rotate, or ping-pong, in which the CPU and the external masters take turns.

Arbitration only takes place while the bus is idle. An owner keeps its grant for as long as it keeps requesting. Each requester has a retry mask counter that takes it out of arbitration for a set number of clocks after one of its transactions is retried. A dead-owner timer takes the grant back from an owner that leaves the bus idle for too long without starting a cycle.

The owner can assert a lock. In total-lock mode the lock reserves the whole bus for the locking requester. In resource-lock mode arbitration carries on as normal, and the lock state and the locker's index are reported so that the target can refuse any other master.

Top module: `four_req_arbiter`

## Requirements
- R1: After reset `gnt_o` is 0000 and `lock_active_o` is 0.
- R2: At most one bit of `gnt_o` is set at any time. `gnt_o` does not change at a clock edge where `bus_idle_i` is 0.
- R3: Mode 00 is fixed priority. When a new winner is chosen, `req_i[0]` (CPU) has the highest priority, then bits 1, 2 and 3.
- R4: Mode 01 is rotating. The winner is the first eligible index after the last granted index, counting upward modulo 4 across all four requesters.
- R5: Mode 10 is hybrid. The CPU (bit 0) wins whenever it is eligible. Otherwise the winner is the first eligible external index (1 to 3) after the last external index granted.
- R6: Mode 11 is ping-pong. If the CPU and at least one external master are both eligible, the CPU wins unless the previous grant went to the CPU, in which case the external master next in rotation wins. If only one side is eligible, that side wins.
- R7: A granted requester keeps its grant while it still requests and is eligible. A new winner is chosen only on an idle edge where the owner is not eligible, or when the dead timer expires.
- R8: A `retry_i` edge loads the owner's mask counter with `retry_reload_i`. The counter then counts down once per clock, and the requester is ineligible while its count is nonzero. A reload of 0 has no effect on the grant.
- R9: On the 16th consecutive clock edge after a grant at which the bus is idle and `frame_start_i` is low, the grant is revoked. The owner is excluded from that one decision only.
- R10: `frame_start_i` high, or the bus being busy, restarts the dead timer, so the grant holds for any length of time.
- R11: If `lock_i` is high while a grant is held, a lock is taken, with `lock_owner_o` set to the owner's index. In total-lock mode (`lock_total_i`=1) only the locker can be granted while the lock is active.
- R12: In resource-lock mode (`lock_total_i`=0) other requesters are still granted while the lock is active. Throughout that time `lock_active_o` stays 1 and `lock_owner_o` stays equal to the locker.
- R13: The lock is released at the first edge at which `lock_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Policy select: 00 fixed, 01 rotating, 10 hybrid, 11 ping-pong |
| lock_total_i | input | 1 | 1: a lock reserves the whole bus; 0: a lock reserves only the target |
| retry_reload_i | input | 4 | Mask length in clocks, loaded when a transaction is retried |
| req_i | input | 4 | Requests; bit 0 is the CPU, bits 1 to 3 are the external masters |
| bus_idle_i | input | 1 | The bus is idle, so the grant may change |
| frame_start_i | input | 1 | The owner has started a cycle |
| retry_i | input | 1 | The owner's transaction was retried |
| lock_i | input | 1 | The owner holds the lock signal |
| gnt_o | output | 4 | One-hot-or-zero grant, registered |
| lock_active_o | output | 1 | A lock is held |
| lock_owner_o | output | 2 | Index of the requester holding the lock |

## Verification
`gnt_o` and the lock outputs are registered. Any decision is therefore visible one clock edge after the inputs that caused it. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sees exactly one rising edge.

Some results are due later, and the bench checks them on exact counts:
- The dead-timer revocation is checked 16 edges after the grant, with the grant confirmed as still held on each of the 15 edges before it.
- A retry with a mask of 3 is expected to remove the grant for exactly three samples, with the grant returning on the fourth.
- The lock release is checked on the edge at which `lock_i` falls.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_FIXED  = 2'b00,
    ARB_ROTATE = 2'b01,
    ARB_HYBRID = 2'b10,
    ARB_PINGPG = 2'b11
  } arb_mode_e;
endpackage

// File: rtl/arb_policy.sv
module arb_policy
  import arb_pkg::*;
#(
  parameter int N_REQ = 4,
  localparam int IDX_W = $clog2(N_REQ)
) (
  input  arb_mode_e          mode_i,
  input  logic [N_REQ-1:0]   elig_i,
  input  logic [IDX_W-1:0]   rr_ptr_i,
  input  logic [IDX_W-1:0]   ext_ptr_i,
  input  logic               last_cpu_i,
  output logic               win_vld_o,
  output logic [IDX_W-1:0]   win_idx_o
);
  // returns {hit, idx}: first set bit after ptr, wrapping
  function automatic logic [IDX_W:0] rr_pick(input logic [N_REQ-1:0] v,
                                             input logic [IDX_W-1:0] ptr);
    logic [IDX_W:0] r;
    int j;
    r = '0;
    for (int k = N_REQ; k >= 1; k--) begin
      j = (int'(ptr) + k) % N_REQ;
      if (v[j]) r = {1'b1, IDX_W'(j)};
    end
    return r;
  endfunction

  function automatic logic [IDX_W:0] fix_pick(input logic [N_REQ-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  logic [N_REQ-1:0] ext_v;
  logic [IDX_W:0]   fix_r, all_r, ext_r, sel_r;
  logic             cpu_e, ext_e;

  assign ext_v = {elig_i[N_REQ-1:1], 1'b0};
  assign fix_r = fix_pick(elig_i);
  assign all_r = rr_pick(elig_i, rr_ptr_i);
  assign ext_r = rr_pick(ext_v, ext_ptr_i);
  assign cpu_e = elig_i[0];
  assign ext_e = |ext_v;

  always_comb begin
    unique case (mode_i)
      ARB_FIXED:  sel_r = fix_r;
      ARB_ROTATE: sel_r = all_r;
      ARB_HYBRID: sel_r = cpu_e ? {1'b1, IDX_W'(0)} : ext_r;
      ARB_PINGPG: begin
        if (cpu_e && ext_e) sel_r = last_cpu_i ? ext_r : {1'b1, IDX_W'(0)};
        else if (cpu_e)     sel_r = {1'b1, IDX_W'(0)};
        else                sel_r = ext_r;
      end
      default:    sel_r = fix_r;
    endcase
  end

  assign win_vld_o = sel_r[IDX_W];
  assign win_idx_o = sel_r[IDX_W-1:0];
endmodule

// File: rtl/arb_retry_mask.sv
module arb_retry_mask #(
  parameter int N_REQ = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retry_i,
  input  logic [N_REQ-1:0] owner_oh_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [N_REQ-1:0] masked_o
);
  for (genvar g = 0; g < N_REQ; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             load;
    assign load = retry_i && owner_oh_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (load)           cnt_q <= reload_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign masked_o[g] = (cnt_q != '0);

    assert_mask_countdown_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1))
      else $error("mask counter skipped a step");
  end
endmodule

// File: rtl/arb_dead_timer.sv
module arb_dead_timer #(
  parameter int DEAD_CYC = 16,
  localparam int DW = $clog2(DEAD_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_vld_i,
  input  logic decide_i,
  input  logic bus_idle_i,
  input  logic frame_start_i,
  output logic expire_o
);
  logic [DW-1:0] cnt_q;
  logic          run;

  assign run      = gnt_vld_i && bus_idle_i && !frame_start_i;
  assign expire_o = run && (cnt_q == DW'(DEAD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (decide_i || !run)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_dead_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0))
    else $error("dead timer kept running after expiry");
  assert_frame_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (cnt_q == '0))
    else $error("dead timer not restarted by cycle start");
endmodule

// File: rtl/arb_lock_track.sv
module arb_lock_track #(
  parameter int N_REQ = 4,
  localparam int IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             gnt_vld_i,
  input  logic [IDX_W-1:0] owner_i,
  output logic             active_o,
  output logic [IDX_W-1:0] owner_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      owner_o  <= '0;
    end else if (!lock_i) begin
      active_o <= 1'b0;
    end else if (!active_o && gnt_vld_i) begin
      active_o <= 1'b1;
      owner_o  <= owner_i;
    end
  end

  assert_lock_release_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !active_o)
    else $error("lock not released");
  assert_lock_owner_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && lock_i) |=> (active_o && $stable(owner_o)))
    else $error("lock owner moved while held");
endmodule

// File: rtl/four_req_arbiter.sv
module four_req_arbiter
  import arb_pkg::*;
#(
  parameter int N_REQ    = 4,
  parameter int RETRY_W  = 4,
  parameter int DEAD_CYC = 16,
  localparam int IDX_W   = $clog2(N_REQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               lock_total_i,
  input  logic [RETRY_W-1:0] retry_reload_i,
  input  logic [N_REQ-1:0]   req_i,
  input  logic               bus_idle_i,
  input  logic               frame_start_i,
  input  logic               retry_i,
  input  logic               lock_i,
  output logic [N_REQ-1:0]   gnt_o,
  output logic               lock_active_o,
  output logic [IDX_W-1:0]   lock_owner_o
);
  logic             gnt_vld_q, last_cpu_q;
  logic [IDX_W-1:0] gnt_idx_q, rr_ptr_q, ext_ptr_q;
  logic [N_REQ-1:0] owner_oh, retry_masked, lock_filt, elig, elig_pol;
  logic             expire, owner_ok, decide, win_vld;
  logic [IDX_W-1:0] win_idx;
  arb_mode_e        mode;

  assign mode      = arb_mode_e'(mode_i);
  assign owner_oh  = gnt_vld_q ? (N_REQ'(1) << gnt_idx_q) : '0;
  assign lock_filt = (lock_active_o && lock_total_i) ? (N_REQ'(1) << lock_owner_o) : '1;
  assign elig      = req_i & ~retry_masked & lock_filt;
  assign elig_pol  = expire ? (elig & ~owner_oh) : elig;
  assign owner_ok  = |(elig & owner_oh);
  assign decide    = bus_idle_i && (!owner_ok || expire);

  arb_retry_mask #(.N_REQ(N_REQ), .CNT_W(RETRY_W)) u_retry (
    .clk_i, .rst_ni, .retry_i, .owner_oh_i(owner_oh),
    .reload_i(retry_reload_i), .masked_o(retry_masked));

  arb_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i, .rst_ni, .gnt_vld_i(gnt_vld_q), .decide_i(decide),
    .bus_idle_i, .frame_start_i, .expire_o(expire));

  arb_lock_track #(.N_REQ(N_REQ)) u_lock (
    .clk_i, .rst_ni, .lock_i, .gnt_vld_i(gnt_vld_q), .owner_i(gnt_idx_q),
    .active_o(lock_active_o), .owner_o(lock_owner_o));

  arb_policy #(.N_REQ(N_REQ)) u_policy (
    .mode_i(mode), .elig_i(elig_pol), .rr_ptr_i(rr_ptr_q), .ext_ptr_i(ext_ptr_q),
    .last_cpu_i(last_cpu_q), .win_vld_o(win_vld), .win_idx_o(win_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_vld_q  <= 1'b0;
      gnt_idx_q  <= '0;
      rr_ptr_q   <= IDX_W'(N_REQ - 1);
      ext_ptr_q  <= IDX_W'(N_REQ - 1);
      last_cpu_q <= 1'b0;
    end else if (decide) begin
      gnt_vld_q <= win_vld;
      gnt_idx_q <= win_idx;
      if (win_vld) begin
        rr_ptr_q   <= win_idx;
        last_cpu_q <= (win_idx == '0);
        if (win_idx != '0) ext_ptr_q <= win_idx;
      end
    end
  end

  assign gnt_o = owner_oh;

  assert_onehot_gnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o))
    else $error("more than one grant");
  assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_idle_i |=> $stable(gnt_o))
    else $error("grant moved while bus busy");
  assert_dead_revoke_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (gnt_o != $past(gnt_o)))
    else $error("expired owner kept grant");
  assert_total_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_active_o && lock_total_i) |=>
      (gnt_o == '0 || $stable(gnt_o) || gnt_o[$past(lock_owner_o)]))
    else $error("non-locker granted under total lock");

  for (genvar g = 0; g < N_REQ; g++) begin : g_chk
    assert_masked_no_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (retry_masked[g] && !gnt_o[g]) |=> !gnt_o[g])
      else $error("masked requester granted");
  end
endmodule

// File: tb/four_req_arbiter_test.sv
`timescale 1ns/1ps
module four_req_arbiter_test;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic       lock_total_i = 1'b0;
  logic [3:0] retry_reload_i = '0;
  logic [3:0] req_i = '0;
  logic       bus_idle_i = 1'b1, frame_start_i = 1'b0, retry_i = 1'b0, lock_i = 1'b0;
  logic [3:0] gnt_o;
  logic       lock_active_o;
  logic [1:0] lock_owner_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  four_req_arbiter uut (.clk_i(clk), .*);

  // {mode[10:9], req[8:5], idle[4], expected grant[3:0]}
  localparam logic [10:0] VEC [23] = '{
    {2'b00,4'b0000,1'b1,4'b0000}, {2'b00,4'b1110,1'b1,4'b0010},
    {2'b00,4'b1111,1'b1,4'b0010}, {2'b00,4'b1101,1'b1,4'b0001},
    {2'b00,4'b1100,1'b0,4'b0001}, {2'b00,4'b1100,1'b1,4'b0100},
    {2'b01,4'b1111,1'b1,4'b0100}, {2'b01,4'b1011,1'b1,4'b1000},
    {2'b01,4'b0111,1'b1,4'b0001}, {2'b01,4'b0110,1'b1,4'b0010},
    {2'b01,4'b0101,1'b1,4'b0100}, {2'b10,4'b1011,1'b1,4'b0001},
    {2'b10,4'b1010,1'b1,4'b1000}, {2'b10,4'b0011,1'b1,4'b0001},
    {2'b10,4'b1110,1'b1,4'b0010}, {2'b11,4'b1101,1'b1,4'b0001},
    {2'b11,4'b1100,1'b1,4'b0100}, {2'b11,4'b1001,1'b1,4'b0001},
    {2'b11,4'b1110,1'b1,4'b1000}, {2'b11,4'b0001,1'b1,4'b0001},
    {2'b11,4'b0000,1'b1,4'b0000}, {2'b11,4'b1001,1'b1,4'b1000},
    {2'b11,4'b0000,1'b1,4'b0000}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive after a falling edge, sample at the next falling edge (one rising edge between)
  task automatic step(input logic [3:0] rq, input logic idl, input logic frm,
                      input logic rty, input logic lk);
    req_i = rq; bus_idle_i = idl; frame_start_i = frm; retry_i = rty; lock_i = lk;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 grant", int'(gnt_o), 0);
    check("R1 lock", int'(lock_active_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 23; i++) begin
      string tag;
      mode_i = VEC[i][10:9];
      step(VEC[i][8:5], VEC[i][4], 1'b0, 1'b0, 1'b0);
      if (i == 2 || i == 6) tag = "R7 hold";
      else if (i == 4)      tag = "R2 busy";
      else case (VEC[i][10:9])
        2'b00:   tag = "R3 fixed";
        2'b01:   tag = "R4 rotate";
        2'b10:   tag = "R5 hybrid";
        default: tag = "R6 pingpong";
      endcase
      check(tag, int'(gnt_o), int'(VEC[i][3:0]));
    end

    mode_i = 2'b00;
    // R9 dead timer: revoke on 16th idle edge, other requester wins
    step(4'b0110, 1, 0, 0, 0); check("R9 grant", int'(gnt_o), 4'b0010);
    for (int i = 0; i < 15; i++) begin
      step(4'b0110, 1, 0, 0, 0); check("R9 before expiry", int'(gnt_o), 4'b0010);
    end
    step(4'b0110, 1, 0, 0, 0); check("R9 expiry", int'(gnt_o), 4'b0100);
    step(4'b0110, 1, 0, 0, 0); check("R9 new owner held", int'(gnt_o), 4'b0100);
    step(4'b0000, 1, 0, 0, 0);
    // R9 lone requester: excluded for one decision only
    step(4'b0010, 1, 0, 0, 0);
    for (int i = 0; i < 15; i++) step(4'b0010, 1, 0, 0, 0);
    check("R9 lone held", int'(gnt_o), 4'b0010);
    step(4'b0010, 1, 0, 0, 0); check("R9 lone revoked", int'(gnt_o), 4'b0000);
    step(4'b0010, 1, 0, 0, 0); check("R9 lone regrant", int'(gnt_o), 4'b0010);
    // R10 cycle starts keep the timer from expiring
    for (int i = 0; i < 20; i++) step(4'b0010, 1, 1, 0, 0);
    check("R10 held with starts", int'(gnt_o), 4'b0010);
    for (int i = 0; i < 15; i++) step(4'b0010, 1, 0, 0, 0);
    check("R10 timer restarted", int'(gnt_o), 4'b0010);
    step(4'b0000, 1, 0, 0, 0);
    step(4'b0000, 1, 0, 0, 0); check("R10 release", int'(gnt_o), 0);

    // R8 retry mask of 3
    retry_reload_i = 4'd3;
    step(4'b0010, 1, 0, 0, 0); check("R8 grant", int'(gnt_o), 4'b0010);
    step(4'b0010, 0, 0, 1, 0); check("R8 retry edge", int'(gnt_o), 4'b0010);
    for (int i = 0; i < 3; i++) begin
      step(4'b0010, 1, 0, 0, 0); check("R8 masked", int'(gnt_o), 0);
    end
    step(4'b0010, 1, 0, 0, 0); check("R8 unmasked", int'(gnt_o), 4'b0010);
    retry_reload_i = 4'd0;
    step(4'b0010, 0, 0, 1, 0);
    step(4'b0010, 1, 0, 0, 0); check("R8 zero reload", int'(gnt_o), 4'b0010);
    step(4'b0000, 1, 0, 0, 0);

    // R11 total lock
    lock_total_i = 1'b1;
    step(4'b0100, 1, 0, 0, 0); check("R11 grant", int'(gnt_o), 4'b0100);
    step(4'b0100, 0, 0, 0, 1);
    check("R11 lock taken", int'(lock_active_o), 1);
    check("R11 lock owner", int'(lock_owner_o), 2);
    step(4'b0011, 1, 0, 0, 1); check("R11 others blocked", int'(gnt_o), 0);
    step(4'b0111, 1, 0, 0, 1); check("R11 locker only", int'(gnt_o), 4'b0100);
    step(4'b0011, 1, 0, 0, 0);
    check("R13 released", int'(lock_active_o), 0);
    step(4'b0011, 1, 0, 0, 0); check("R13 others after release", int'(gnt_o), 4'b0001);
    step(4'b0000, 1, 0, 0, 0);

    // R12 resource lock
    lock_total_i = 1'b0;
    step(4'b0100, 1, 0, 0, 0);
    step(4'b0100, 0, 0, 0, 1);
    step(4'b0011, 1, 0, 0, 1);
    check("R12 other granted", int'(gnt_o), 4'b0001);
    check("R12 lock active", int'(lock_active_o), 1);
    check("R12 lock owner", int'(lock_owner_o), 2);
    step(4'b0011, 1, 0, 0, 0); check("R13 resource release", int'(lock_active_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule